// File: doc/BRIEF.md
# IO Register Bit Access Unit

This unit executes three short instructions of an 8-bit microcontroller datapath. Two of them change one bit of an IO register: clear-bit and set-bit. The third copies an IO register byte into a general register. The unit receives a 16-bit instruction word together with a valid strobe and decodes it. It maps the IO address onto the unified data space by adding a fixed base. It then drives a combinational data-space port: an address, a read byte returned by the memory, a write byte and a write strobe. Register reads use a separate register-file write port.

Each completed instruction raises a one-cycle completion pulse. With that pulse the unit reports how far the program counter moves and how many cycles the instruction took. Clear-bit and the IO read each finish in the cycle they are presented. Set-bit presents its address in the first cycle and completes in the second. During that second cycle the unit is busy and ignores any new instruction. Words that match none of the three patterns are ignored.

Top module: `ioBitUnit`

## Requirements
- R1: A word whose bits [15:8] equal 0x98 is a clear-bit instruction. Bits [7:3] give the IO address A and bits [2:0] give the bit index. The data-space address driven is A + 0x20, so 0x9865 targets address 0x2C, bit 5.
- R2: Clear-bit writes the read byte with only the selected bit forced to 0 (0xFF becomes 0xDF for bit 5). It completes in the cycle it is presented, with cycleCount = 1.
- R3: A word whose bits [15:8] equal 0x9A is a set-bit instruction, with the same address and bit fields as R1. It performs no write in its first cycle. In the second cycle it writes the byte present at that time with only the selected bit forced to 1 (0x0F becomes 0x2F for bit 5). It completes with cycleCount = 2.
- R4: A word whose bits [15:11] equal 10110 is an IO read. The IO address is {bits[10:9], bits[3:0]} and the destination register is bits[8:4]. The unit drives address IO + 0x20 and writes the byte read there into the register file through its register port, in the same cycle, with cycleCount = 1 and no data-space write.
- R5: Every completion pulse reports a program counter increment of 1.
- R6: busy is high exactly in the second cycle of set-bit. An instruction presented in that cycle is ignored.
- R7: A valid word matching none of the three patterns causes no write of either kind and no completion pulse.
- R8: While reset is asserted and in the first idle cycle after it, no write strobe, completion or busy is active.
- R9: A data-space write and a register write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word present this cycle |
| instWord | input | 16 | Instruction word |
| memRdata | input | 8 | Byte read combinationally at memAddr |
| memAddr | output | ADDR_W (16) | Data-space address |
| memWe | output | 1 | Data-space write strobe |
| memWdata | output | 8 | Data-space write byte |
| regWe | output | 1 | Register-file write strobe |
| regAddr | output | 5 | Destination general register |
| regWdata | output | 8 | Byte written to the register |
| done | output | 1 | Instruction completes this cycle |
| busy | output | 1 | Second cycle of set-bit; new words ignored |
| cycleCount | output | 2 | Cycles taken by the completing instruction |
| pcInc | output | 2 | Program counter increment of the completing instruction |

## Verification
Two functions can fall in the same cycle: the write that completes a set-bit, and the acceptance of a new instruction. The bench provokes this by holding a valid clear-bit word during the set-bit's busy cycle. In that same cycle it also rewrites the target byte in the memory model. A behavioural reference model is compared every clock. The result is judged correct only if the set-write alone occurs, it is built on the rewritten byte, and the clear-bit leaves no trace.

// File: rtl/ioBitPkg.sv
package ioBitPkg;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int IO_AW  = 6;
  localparam int REG_AW = 5;

  typedef struct packed {
    logic              memAcc;
    logic              memWe;
    logic              regWe;
    logic              setMode;
    logic [IO_AW-1:0]  ioAddr;
    logic [BIT_W-1:0]  bitIdx;
    logic [REG_AW-1:0] regDst;
  } strobeT;
endpackage

// File: rtl/ioBitCtrl.sv
module ioBitCtrl
  import ioBitPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instValid,
  input  logic [15:0] instWord,
  output strobeT      stb,
  output logic        done,
  output logic        busy,
  output logic [1:0]  cycles,
  output logic [1:0]  pcStep
);
  logic isClr, isSet, isRead, known;
  logic inSetWr;
  logic [IO_AW-1:0] pendAddr;
  logic [BIT_W-1:0] pendBit;
  logic [IO_AW-1:0] bitAddr, readAddr;

  assign isClr    = (instWord[15:8] == 8'h98);
  assign isSet    = (instWord[15:8] == 8'h9A);
  assign isRead   = (instWord[15:11] == 5'b10110);
  assign known    = isClr | isSet | isRead;
  assign bitAddr  = {1'b0, instWord[7:3]};
  assign readAddr = {instWord[10:9], instWord[3:0]};

  always_comb begin
    stb    = '0;
    done   = 1'b0;
    cycles = 2'd0;
    pcStep = 2'd0;
    if (inSetWr) begin
      stb.memAcc  = 1'b1;
      stb.memWe   = 1'b1;
      stb.setMode = 1'b1;
      stb.ioAddr  = pendAddr;
      stb.bitIdx  = pendBit;
      done        = 1'b1;
      cycles      = 2'd2;
      pcStep      = 2'd1;
    end else if (instValid) begin
      if (isClr) begin
        stb.memAcc = 1'b1;
        stb.memWe  = 1'b1;
        stb.ioAddr = bitAddr;
        stb.bitIdx = instWord[2:0];
        done       = 1'b1;
        cycles     = 2'd1;
        pcStep     = 2'd1;
      end else if (isSet) begin
        stb.memAcc = 1'b1;
        stb.ioAddr = bitAddr;
        stb.bitIdx = instWord[2:0];
      end else if (isRead) begin
        stb.memAcc = 1'b1;
        stb.regWe  = 1'b1;
        stb.ioAddr = readAddr;
        stb.regDst = instWord[8:4];
        done       = 1'b1;
        cycles     = 2'd1;
        pcStep     = 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inSetWr  <= 1'b0;
      pendAddr <= '0;
      pendBit  <= '0;
    end else if (inSetWr) begin
      inSetWr <= 1'b0;
    end else if (instValid && isSet) begin
      inSetWr  <= 1'b1;
      pendAddr <= bitAddr;
      pendBit  <= instWord[2:0];
    end
  end

  assign busy = inSetWr;

  // R3: the set-bit write phase lasts exactly one cycle
  assert_setwr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R6: busy cycle always carries the set-bit write and its completion
  assert_busy_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stb.memWe && stb.setMode && done && cycles == 2'd2));
  // R7: an unrecognised word does nothing
  assert_unknown_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !busy && !known) |-> (!stb.memWe && !stb.regWe && !done));
  // R3: set-bit first cycle writes nothing and raises busy next
  assert_set_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !busy && isSet) |-> (!stb.memWe && !done) ##1 busy);
endmodule

// File: rtl/ioBitDp.sv
module ioBitDp
  import ioBitPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IO_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              regWe,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata
);
  logic [DATA_W-1:0] newByte;

  assign memAddr = stb.memAcc ? (ADDR_W'(stb.ioAddr) + ADDR_W'(IO_BASE)) : '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign newByte[i] = !stb.memWe ? 1'b0 :
                        (stb.bitIdx == BIT_W'(i)) ? stb.setMode : memRdata[i];
  end

  assign memWe    = stb.memWe;
  assign memWdata = newByte;
  assign regWe    = stb.regWe;
  assign regAddr  = stb.regWe ? stb.regDst : '0;
  assign regWdata = stb.regWe ? memRdata : '0;

  // R2/R3: the seven unselected bits pass through unchanged
  assert_other_bits_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> ($countones(memWdata ^ memRdata) <= 1));
  // R1: every access lands in the IO window of the data space
  assert_io_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || regWe) |-> (memAddr >= ADDR_W'(IO_BASE) && memAddr < ADDR_W'(IO_BASE + 64)));
  // R4: the register port receives exactly the byte read
  assert_read_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |-> (regWdata == memRdata));
endmodule

// File: rtl/ioBitUnit.sv
module ioBitUnit
  import ioBitPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IO_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              regWe,
  output logic [4:0]        regAddr,
  output logic [7:0]        regWdata,
  output logic              done,
  output logic              busy,
  output logic [1:0]        cycleCount,
  output logic [1:0]        pcInc
);
  strobeT stb;

  ioBitCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .stb(stb), .done(done), .busy(busy), .cycles(cycleCount), .pcStep(pcInc)
  );

  ioBitDp #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata)
  );

  // R5: each completion advances the program counter by one word
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pcInc == 2'd1));
  // R9: never both write ports in one cycle
  assert_single_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWe && regWe));
  // R2/R4: a one-cycle completion is always accompanied by its write
  assert_done_has_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cycleCount == 2'd1) |-> (memWe || regWe));
endmodule

// File: tb/sim_ioBitUnit.sv
`timescale 1ns/1ps
module sim_ioBitUnit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instValid = 1'b0;
  logic [15:0] instWord = '0;
  logic [7:0] memRdata;
  logic [15:0] memAddr;
  logic memWe, regWe, done, busy;
  logic [7:0] memWdata, regWdata;
  logic [4:0] regAddr;
  logic [1:0] cycleCount, pcInc;

  logic [7:0] mem [128];
  int total = 0;
  int bad = 0;
  int pending = 0;
  int pAddr = 0;
  int pBit = 0;

  always #2.5 clk = ~clk;

  assign memRdata = mem[memAddr[6:0]];

  ioBitUnit u0 (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .done(done),
    .busy(busy), .cycleCount(cycleCount), .pcInc(pcInc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive, optionally rewrite a byte, compare with the model, commit
  task automatic cyc(input logic v, input logic [15:0] w, input int pokeA, input int pokeV);
    int eMemWe, eRegWe, eDone, eBusy, eCyc, eAddr, eWd, eRa, eRd;
    @(negedge clk);
    instValid = v;
    instWord  = w;
    if (pokeA >= 0) mem[pokeA] = 8'(pokeV);
    #1;
    eMemWe = 0; eRegWe = 0; eDone = 0; eBusy = 0; eCyc = 0;
    eAddr = 0; eWd = 0; eRa = 0; eRd = 0;
    if (pending != 0) begin
      eBusy = 1; eMemWe = 1; eDone = 1; eCyc = 2;
      eAddr = pAddr + 32;
      eWd = mem[eAddr] | (1 << pBit);
      pending = 0;
    end else if (v) begin
      if (w[15:8] == 8'h98) begin
        eMemWe = 1; eDone = 1; eCyc = 1;
        eAddr = int'(w[7:3]) + 32;
        eWd = mem[eAddr] & ~(1 << int'(w[2:0]));
      end else if (w[15:8] == 8'h9A) begin
        pending = 1; pAddr = int'(w[7:3]); pBit = int'(w[2:0]);
      end else if (w[15:11] == 5'b10110) begin
        eRegWe = 1; eDone = 1; eCyc = 1;
        eAddr = int'({w[10:9], w[3:0]}) + 32;
        eRa = int'(w[8:4]);
        eRd = mem[eAddr];
      end
    end
    chk("R6 busy", busy, eBusy);
    chk("R7 memWe", memWe, eMemWe);
    chk("R7 regWe", regWe, eRegWe);
    chk("R7 done", done, eDone);
    chk("R9 dual write", memWe & regWe, 0);
    if (eMemWe != 0) begin
      chk("R1 memAddr", memAddr, eAddr);
      chk(eCyc == 2 ? "R3 set byte" : "R2 clear byte", memWdata, eWd);
    end
    if (eRegWe != 0) begin
      chk("R4 memAddr", memAddr, eAddr);
      chk("R4 regAddr", regAddr, eRa);
      chk("R4 regWdata", regWdata, eRd);
    end
    if (eDone != 0) begin
      chk(eCyc == 2 ? "R3 cycles" : "R2 cycles", cycleCount, eCyc);
      chk("R5 pcInc", pcInc, 1);
    end
    if (eMemWe != 0) mem[eAddr] = 8'(eWd);
    if (eRegWe != 0) mem[eRa] = 8'(eRd);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk("R8 reset memWe", memWe, 0);
    chk("R8 reset done", done, 0);
    chk("R8 reset busy", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 16'h0000, -1, 0);

    // R1 R2: clear bit 5 of IO 0x0C (data 0x2C)
    cyc(1'b1, 16'h9865, 8'h2C, 8'hFF);
    chk("R2 literal 0xDF", mem[8'h2C], 8'hDF);
    // R3: set bit 5 of IO 0x0C
    cyc(1'b1, 16'h9A65, 8'h2C, 8'h0F);
    cyc(1'b0, 16'h0000, -1, 0);
    chk("R3 literal 0x2F", mem[8'h2C], 8'h2F);
    // R3 R6: byte changes between the two set-bit cycles, clear-bit held meanwhile
    cyc(1'b1, 16'h9A65, 8'h2C, 8'h00);
    cyc(1'b1, 16'h9860, 8'h2C, 8'h81);
    chk("R6 literal 0xA1", mem[8'h2C], 8'hA1);
    // R4: IN r5 from IO 0x0B
    cyc(1'b1, 16'hB05B, 8'h2B, 8'hAF);
    chk("R4 literal r5", mem[5], 8'hAF);
    // R4: top IO address into r31
    cyc(1'b1, 16'hB7FF, 8'h5F, 8'h3C);
    chk("R4 literal r31", mem[31], 8'h3C);
    // R1 R2 R3: edge bits and addresses
    cyc(1'b1, 16'h98F8, 8'h3F, 8'hFF);
    chk("R2 literal bit0", mem[8'h3F], 8'hFE);
    cyc(1'b1, 16'h9A07, 8'h20, 8'h00);
    cyc(1'b1, 16'h9A07, -1, 0);
    chk("R3 literal bit7", mem[8'h20], 8'h80);
    // R7: unknown words
    cyc(1'b1, 16'h0000, -1, 0);
    cyc(1'b1, 16'h9900, -1, 0);
    cyc(1'b1, 16'hB85B, -1, 0);
    // back-to-back: set-bit then immediately clear-bit
    cyc(1'b1, 16'h9A11, -1, 0);
    cyc(1'b0, 16'h0000, -1, 0);
    cyc(1'b1, 16'h9811, -1, 0);
    // mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: w = {8'h98, lfsr[15:8]};
        2'd1: w = {8'h9A, lfsr[15:8]};
        2'd2: w = {5'b10110, lfsr[13:3]};
        default: w = {lfsr[7:0], lfsr[15:8]};
      endcase
      cyc(lfsr[9] | lfsr[4], w, (lfsr[6:5] == 2'b11) ? int'(lfsr[12:8]) + 32 : -1, int'(lfsr[15:8]));
    end
    cyc(1'b0, 16'h0000, -1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule